// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block chooses which of eight level-sensitive interrupt request lines should be presented to a processor. It keeps three registers: the pending requests, the levels currently in service, and the position of the lowest-priority level on a circular priority ring. A level may be requested only when it is pending, not masked, not already in service, and ranked above every level now in service. Under that rule a more urgent level can interrupt the handler of a less urgent one. When the processor acknowledges, the block reports the winning level and marks it in service. In automatic end-of-interrupt mode the level is not marked; if automatic rotation is also on, the level is moved to the bottom of the ring.

Software controls the block with one-byte command words. A command can end an interrupt, either the most urgent one in service or a named one. It can also move the bottom of the ring to the level it ends or to a named level. A command can also switch automatic rotation on or off. The mask and the automatic end-of-interrupt mode select are plain inputs, and the in-service vector and the bottom of the ring are visible outputs.

Top module: `irq_ring_resolver`

## Requirements
- R1: After a synchronous reset, in_service is 0, lowest_level is 7 (so level 0 ranks highest), automatic rotation is off, and int_req and ack_valid are 0.
- R2: Rank runs around the ring from lowest_level+1 (highest) to lowest_level (lowest). On ack, the highest-ranked level that is pending, unmasked and not in service is reported on ack_level with ack_valid high for one cycle. In normal mode that level's in_service bit is set.
- R3: int_req is raised only when the best candidate outranks every level in service. A candidate of lower rank waits until the levels above it are ended. int_req drops in the cycle after ack.
- R4: A masked level is never requested. Its pending state is kept, so it is requested once the mask bit is cleared while the line is still high.
- R5: Command bits are: bit 7 rotate flag, bit 6 select-level flag, bit 5 end flag, bits 2..0 level. Code 001 (bits 7..5) clears the highest-ranked in_service bit. If in_service is 0, the command changes neither in_service nor lowest_level.
- R6: Code 011 clears only the in_service bit named in bits 2..0.
- R7: Code 101 clears the highest-ranked in_service bit and makes that level the lowest. If in_service is 0, nothing changes.
- R8: Code 111 clears the in_service bit named in bits 2..0 and makes that level the lowest.
- R9: Code 110 makes the named level the lowest without clearing any in_service bit. Code 010 has no effect.
- R10: With aeoi_mode high, ack sets no in_service bit. Code 100 turns automatic rotation on and code 000 turns it off. While it is on, each acknowledged level becomes lowest_level.
- R11: A change on irq_lines reaches int_req on the second rising edge after it. ack_valid, ack_level, in_service and lowest_level update on the edge that samples ack or cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Level-sensitive request lines, bit n = level n |
| mask | input | 8 | Mask bit n set blocks level n from arbitration |
| aeoi_mode | input | 1 | High selects automatic end of interrupt |
| cmd_valid | input | 1 | Command byte strobe, one cycle |
| cmd_byte | input | 8 | Command word |
| ack | input | 1 | Processor acknowledge, one cycle |
| int_req | output | 1 | Registered request to the processor |
| ack_valid | output | 1 | One-cycle pulse after a granted ack |
| ack_level | output | 3 | Level granted by the last ack |
| in_service | output | 8 | In-service register |
| lowest_level | output | 3 | Level at the bottom of the priority ring |

## Verification
The assertions assume that ack is pulsed only while int_req is high and the request lines have been stable for at least two cycles. This way the level granted is the one that int_req announced. They also assume that a command and an acknowledge never share a cycle, and that aeoi_mode changes only while no ack is in flight. The stimulus drives every input one step after a rising edge. It holds lines steady across each acknowledge and waits a full cycle after each ack or command before changing mode or lines. It lowers a request line before ending its interrupt, so that an ended level is not granted again by accident.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
  localparam int unsigned LEVELS = 8;
  localparam int unsigned LVL_W  = $clog2(LEVELS);

  // decoded effect of one command word
  typedef struct packed {
    logic end_top;      // clear highest-ranked in-service bit
    logic end_named;    // clear the named in-service bit
    logic rot_to_ended; // bottom of ring moves to the ended top level
    logic bottom_named; // bottom of ring moves to the named level
    logic auto_on;
    logic auto_off;
  } cmd_act_t;
endpackage

// File: rtl/irq_ring_pick.sv
module irq_ring_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] bottom_i,
  output logic          found_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] rank_o
);
  // walk the ring from the lowest rank towards the highest; the last hit wins
  always_comb begin
    found_o = 1'b0;
    level_o = '0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [LW-1:0] idx;
      idx = bottom_i + LW'(1) + LW'(k);
      if (vec_i[idx]) begin
        found_o = 1'b1;
        level_o = idx;
        rank_o  = LW'(k);
      end
    end
  end

  // R2: a reported winner must be a requesting level
  always_comb begin
    if (found_o) begin
      a_r2_pick_hit: assert (vec_i[level_o]);
    end
  end
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_ring_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output cmd_act_t   act_o
);
  logic rot, sel, fin;
  assign rot = byte_i[7];
  assign sel = byte_i[6];
  assign fin = byte_i[5];

  always_comb begin
    act_o = '0;
    if (valid_i) begin
      unique case ({rot, sel, fin})
        3'b001: act_o.end_top      = 1'b1;
        3'b011: act_o.end_named    = 1'b1;
        3'b101: begin
          act_o.end_top      = 1'b1;
          act_o.rot_to_ended = 1'b1;
        end
        3'b111: begin
          act_o.end_named    = 1'b1;
          act_o.bottom_named = 1'b1;
        end
        3'b110: act_o.bottom_named = 1'b1;
        3'b100: act_o.auto_on      = 1'b1;
        3'b000: act_o.auto_off     = 1'b1;
        default: act_o = '0; // 010: no action
      endcase
    end
  end
endmodule

// File: rtl/irq_ring_resolver.sv
module irq_ring_resolver
  import irq_ring_pkg::*;
#(
  parameter int unsigned N  = LEVELS,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_lines,
  input  logic [N-1:0]  mask,
  input  logic          aeoi_mode,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          ack,
  output logic          int_req,
  output logic          ack_valid,
  output logic [LW-1:0] ack_level,
  output logic [N-1:0]  in_service,
  output logic [LW-1:0] lowest_level
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  isr_q;
  logic [LW-1:0] bottom_q;
  logic          autorot_q;

  logic          cand_found, top_found;
  logic [LW-1:0] cand_lvl, cand_rank, top_lvl, top_rank;
  logic [LW-1:0] named_lvl;
  logic          grant_ok, take;
  logic [N-1:0]  isr_clr, isr_set;
  cmd_act_t      act;

  assign named_lvl = cmd_byte[LW-1:0];

  irq_cmd_decode u_dec (
    .valid_i (cmd_valid),
    .byte_i  (cmd_byte),
    .act_o   (act)
  );

  irq_ring_pick #(.N(N), .LW(LW)) u_cand (
    .vec_i    (pend_q & ~mask & ~isr_q),
    .bottom_i (bottom_q),
    .found_o  (cand_found),
    .level_o  (cand_lvl),
    .rank_o   (cand_rank)
  );

  irq_ring_pick #(.N(N), .LW(LW)) u_top (
    .vec_i    (isr_q),
    .bottom_i (bottom_q),
    .found_o  (top_found),
    .level_o  (top_lvl),
    .rank_o   (top_rank)
  );

  assign grant_ok = cand_found && (!top_found || (cand_rank < top_rank));
  assign take     = ack && grant_ok;

  always_comb begin
    isr_clr = '0;
    if (act.end_top && top_found) isr_clr[top_lvl] = 1'b1;
    if (act.end_named)            isr_clr[named_lvl] = 1'b1;
    isr_set = '0;
    if (take && !aeoi_mode)       isr_set[cand_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      isr_q     <= '0;
      bottom_q  <= LW'(N - 1);
      autorot_q <= 1'b0;
      int_req   <= 1'b0;
      ack_valid <= 1'b0;
      ack_level <= '0;
    end else begin
      pend_q    <= irq_lines;
      isr_q     <= (isr_q & ~isr_clr) | isr_set;
      int_req   <= grant_ok && !ack;
      ack_valid <= take;
      if (take) ack_level <= cand_lvl;
      if (act.auto_on)       autorot_q <= 1'b1;
      else if (act.auto_off) autorot_q <= 1'b0;
      if (act.bottom_named)                      bottom_q <= named_lvl;
      else if (act.rot_to_ended && top_found)    bottom_q <= top_lvl;
      else if (take && aeoi_mode && autorot_q)   bottom_q <= cand_lvl;
    end
  end

  assign in_service   = isr_q;
  assign lowest_level = bottom_q;

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_service == '0 && lowest_level == LW'(N - 1) && !int_req && !ack_valid));

  // R2: in normal mode the granted level is marked in service
  a_r2_ack_marks: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !aeoi_mode) |-> in_service[ack_level]);

  // R10: automatic end of interrupt leaves the level unmarked
  a_r10_aeoi_unmarked: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && aeoi_mode) |-> !in_service[ack_level]);

  // R5: ending with nothing in service changes nothing
  a_r5_empty_end: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'b001 && in_service == '0 && !ack)
      |=> (in_service == '0 && $stable(lowest_level)));

  // R9: code 010 is inert
  a_r9_inert_code: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'b010 && !ack)
      |=> ($stable(in_service) && $stable(lowest_level)));
endmodule

// File: tb/irq_ring_resolver_test.sv
module irq_ring_resolver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_lines = '0;
  logic [7:0] mask = '0;
  logic       aeoi_mode = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       ack = 1'b0;
  logic       int_req, ack_valid;
  logic [2:0] ack_level, lowest_level;
  logic [7:0] in_service;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  irq_ring_resolver uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .mask(mask),
    .aeoi_mode(aeoi_mode), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ack(ack), .int_req(int_req), .ack_valid(ack_valid),
    .ack_level(ack_level), .in_service(in_service),
    .lowest_level(lowest_level)
  );

  typedef enum int { F_REQ, F_AV, F_LVL, F_ISR, F_LOW } field_t;
  typedef struct { string req; field_t fld; int exp; } item_t;
  item_t sb_q[$];
  event  sample_ev;

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        case (it.fld)
          F_REQ:   act = int'(int_req);
          F_AV:    act = int'(ack_valid);
          F_LVL:   act = int'(ack_level);
          F_ISR:   act = int'(in_service);
          default: act = int'(lowest_level);
        endcase
        checks++;
        if (act != it.exp) begin
          failures++;
          $display("FAIL %s field=%s actual=0x%0h expected=0x%0h",
                   it.req, it.fld.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, field_t f, int e);
    item_t it;
    it.req = req; it.fld = f; it.exp = e;
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_cmd(logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b; step(1); cmd_valid = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_val("R1", F_ISR, 0);
    expect_val("R1", F_LOW, 7);
    expect_val("R1", F_REQ, 0);
    expect_val("R1", F_AV, 0);

    // requests on 2 and 4 together
    irq_lines = 8'h14;
    step(1);
    expect_val("R11", F_REQ, 0);
    step(1);
    expect_val("R11", F_REQ, 1);
    do_ack();
    expect_val("R2", F_AV, 1);
    expect_val("R2", F_LVL, 2);
    expect_val("R2", F_ISR, 8'h04);
    step(1);
    expect_val("R3", F_REQ, 0);
    expect_val("R2", F_AV, 0);

    // level 1 nests over 2
    irq_lines = 8'h16;
    step(2);
    expect_val("R3", F_REQ, 1);
    do_ack();
    expect_val("R3", F_LVL, 1);
    expect_val("R3", F_ISR, 8'h06);
    irq_lines = 8'h14;
    do_cmd(8'h20);
    expect_val("R5", F_ISR, 8'h04);
    expect_val("R5", F_LOW, 7);

    // named end of 2, then 4 becomes eligible
    irq_lines = 8'h10;
    do_cmd(8'h62);
    expect_val("R6", F_ISR, 8'h00);
    step(1);
    expect_val("R6", F_REQ, 1);
    do_ack();
    expect_val("R2", F_LVL, 4);

    // level 3 nests over 4
    irq_lines = 8'h08;
    step(2);
    expect_val("R3", F_REQ, 1);
    do_ack();
    expect_val("R3", F_LVL, 3);
    expect_val("R3", F_ISR, 8'h18);
    irq_lines = 8'h00;

    // rotate on ending the top level
    do_cmd(8'hA0);
    expect_val("R7", F_ISR, 8'h10);
    expect_val("R7", F_LOW, 3);
    do_cmd(8'h20);
    expect_val("R5", F_ISR, 8'h00);
    expect_val("R5", F_LOW, 3);
    do_cmd(8'h20);
    expect_val("R5", F_ISR, 8'h00);
    expect_val("R5", F_LOW, 3);
    do_cmd(8'hA0);
    expect_val("R7", F_LOW, 3);

    // set bottom without ending, inert code
    do_cmd(8'hC4);
    expect_val("R9", F_LOW, 4);
    do_cmd(8'h43);
    expect_val("R9", F_LOW, 4);
    expect_val("R9", F_ISR, 8'h00);

    // ring order 5..4: level 5 beats level 1
    irq_lines = 8'h22;
    step(2);
    do_ack();
    expect_val("R2", F_LVL, 5);
    step(1);
    expect_val("R3", F_REQ, 0);
    irq_lines = 8'h00;
    do_cmd(8'hE5);
    expect_val("R8", F_ISR, 8'h00);
    expect_val("R8", F_LOW, 5);

    // masking keeps the request pending
    mask = 8'h01;
    irq_lines = 8'h01;
    step(3);
    expect_val("R4", F_REQ, 0);
    mask = 8'h00;
    step(2);
    expect_val("R4", F_REQ, 1);
    do_ack();
    expect_val("R4", F_LVL, 0);
    irq_lines = 8'h00;
    do_cmd(8'h60);
    expect_val("R6", F_ISR, 8'h00);

    // automatic end of interrupt with rotation
    step(1);
    aeoi_mode = 1'b1;
    do_cmd(8'h80);
    irq_lines = 8'h0C;
    step(2);
    do_ack();
    expect_val("R10", F_LVL, 2);
    expect_val("R10", F_ISR, 8'h00);
    expect_val("R10", F_LOW, 2);
    step(1);
    do_ack();
    expect_val("R10", F_LVL, 3);
    expect_val("R10", F_LOW, 3);
    do_cmd(8'h00);
    irq_lines = 8'h04;
    step(2);
    do_ack();
    expect_val("R10", F_LVL, 2);
    expect_val("R10", F_LOW, 3);
    irq_lines = 8'h00;
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule